// File: doc/BRIEF.md
# Branch Resolution Unit

This unit executes an already decoded branch for a 64-bit machine that numbers its bits from the most significant end. The unit receives the branch kind, the 5-bit option field (BO), the 5-bit condition-bit selector (BI), the absolute-address flag (AA), the save-return flag (LK), a displacement, the current instruction address, a 32-bit condition register and a target-address register. In the same cycle it decides whether the branch is taken and produces the next instruction address. The counter register and the return-address register are held inside the unit. They are updated on the clock edge at which `valid_i` is high.

The taken decision combines two tests. One is an optional decrement-and-test of the counter, and the counter width used in the zero test depends on the mode. The other tests one bit of the condition register against an expected sense. The next address comes from one of three sources: a sign-extended displacement, which is either absolute or added to the current address; one of the three registers with its two low bits forced to zero; or the fall-through address. Two load strobes let the surrounding pipeline write the counter and the return register directly.

Top module: `brn_resolve_unit`

## Requirements
- R1: While reset is asserted, the counter register (`ctr_o`) and the return register (`lr_o`) read zero.
- R2: The counter decrements by one on a valid cycle only when `bo_i[2]` is 0 and `kind_i` is 1 (conditional relative), 2 (via return register) or 4 (via target register). For every other valid cycle the counter keeps its value. This includes kind 0 (unconditional), kind 3 (via counter) and the unused codes 5 to 7.
- R3: The counter test passes if `bo_i[2]` is 1, or if ((decremented counter ≠ 0) XOR `bo_i[1]`) is true. With `mode64_i`=1 all 64 bits take part in the zero test. With `mode64_i`=0 only bits 31:0 do.
- R4: The condition test passes if `bo_i[4]` is 1, or if `cr_i[31-bi_i]` equals `bo_i[3]`. BI=0 therefore selects the most significant bit.
- R5: Kind 0 is always taken. Kind 3 is taken when the condition test passes. Kinds 1, 2 and 4 are taken when both tests pass. Kinds 5 to 7 are never taken.
- R6: For kind 0 the offset is `disp_i[23:0]` followed by two zero bits, sign-extended to 64 bits. For kind 1 the offset is `disp_i[13:0]` followed by two zero bits, sign-extended. The target equals the offset when `aa_i`=1, and the current address plus the offset when `aa_i`=0.
- R7: Kinds 2, 3 and 4 target the return register, the counter and `tar_i` respectively, with bits 1:0 cleared. The values used are the ones held before this cycle's update.
- R8: When a branch is not taken, `nia_o` is the current address plus 4.
- R9: On a valid cycle with `lk_i`=1, the return register is written with the current address plus 4, whether or not the branch is taken. With `lk_i`=0 it keeps its value.
- R10: With `mode64_i`=0, bits 63:32 of `nia_o` and of the value written to the return register are zero.
- R11: `ld_ctr_i` and `ld_lr_i` write `ld_ctr_val_i` and `ld_lr_val_i` on the clock edge when `valid_i` is low. Both are ignored while `valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | A branch is being executed this cycle |
| kind_i | input | 3 | Branch kind, 0..4 as in R5 |
| bo_i | input | 5 | Branch option field |
| bi_i | input | 5 | Condition-bit selector |
| aa_i | input | 1 | Absolute displacement |
| lk_i | input | 1 | Save return address |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| disp_i | input | 24 | Displacement (low 14 bits for kind 1) |
| cia_i | input | 64 | Current instruction address |
| cr_i | input | 32 | Condition register |
| tar_i | input | 64 | Target-address register |
| ld_ctr_i | input | 1 | Load counter register |
| ld_ctr_val_i | input | 64 | Counter load value |
| ld_lr_i | input | 1 | Load return register |
| ld_lr_val_i | input | 64 | Return register load value |
| taken_o | output | 1 | Branch is taken |
| nia_o | output | 64 | Next instruction address |
| ctr_o | output | 64 | Counter register |
| lr_o | output | 64 | Return register |

## Verification
The bench sweeps all 32 option values across every kind, both modes, both AA and LK settings, three selector positions and four counter seeds, and compares each result with an arithmetic model.

The counter seeds target specific faults:
- A seed of 1 exposes a design that tests the counter before decrementing it, because it would see a nonzero count where the decremented count is zero.
- A seed of 0 exposes a missing wrap to all ones.
- A seed of 0x1_0000_0001 separates a 32-bit zero test from a 64-bit one.

Other parts of the sweep target the remaining faults:
- Selecting bit 0 and bit 31 catches a reversed selector.
- A return register with its low bits set catches unaligned register targets.
- A return-register branch with LK=1 catches the use of the freshly written value as the target.

// File: rtl/brn_pkg.sv
package brn_pkg;
  typedef enum logic [2:0] {
    BK_UNCOND   = 3'd0,
    BK_COND_REL = 3'd1,
    BK_TO_LINK  = 3'd2,
    BK_TO_COUNT = 3'd3,
    BK_TO_TAR   = 3'd4
  } brn_kind_e;

  // option-field bit positions (field bit 0 is the MSB)
  localparam int unsigned BO_NO_CR     = 4;
  localparam int unsigned BO_CR_SENSE  = 3;
  localparam int unsigned BO_NO_CTR    = 2;
  localparam int unsigned BO_CTR_SENSE = 1;
endpackage

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
  import brn_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned CR_W = 32,
  parameter int unsigned FW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      kind_i,
  input  logic [FW-1:0]   bo_i,
  input  logic [FW-1:0]   bi_i,
  input  logic            mode64_i,
  input  logic [CR_W-1:0] cr_i,
  input  logic [XLEN-1:0] ctr_i,
  output logic [XLEN-1:0] ctr_next_o,
  output logic            taken_o
);
  localparam int unsigned HALF = XLEN / 2;

  brn_kind_e       kind;
  logic            uses_ctr;
  logic            dec_en;
  logic            ctr_nz;
  logic            ctr_ok;
  logic            cr_ok;
  logic [FW-1:0]   sel;

  assign kind = brn_kind_e'(kind_i);

  always_comb begin
    uses_ctr   = (kind == BK_COND_REL) || (kind == BK_TO_LINK) || (kind == BK_TO_TAR);
    dec_en     = uses_ctr && !bo_i[BO_NO_CTR];
    ctr_next_o = dec_en ? (ctr_i - XLEN'(1)) : ctr_i;
    ctr_nz     = mode64_i ? (|ctr_next_o) : (|ctr_next_o[HALF-1:0]);
    ctr_ok     = bo_i[BO_NO_CTR] || (ctr_nz ^ bo_i[BO_CTR_SENSE]);
    sel        = FW'(CR_W - 1) - bi_i;
    cr_ok      = bo_i[BO_NO_CR] || (cr_i[sel] == bo_i[BO_CR_SENSE]);
    case (kind)
      BK_UNCOND:                        taken_o = 1'b1;
      BK_COND_REL, BK_TO_LINK, BK_TO_TAR: taken_o = ctr_ok && cr_ok;
      BK_TO_COUNT:                      taken_o = cr_ok;
      default:                          taken_o = 1'b0;
    endcase
  end

  // R5: unconditional kind must always resolve taken
  a_r5_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == BK_UNCOND) |-> taken_o);
  // R5: unused kind codes never taken
  a_r5_reserved_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i > BK_TO_TAR) |-> !taken_o);
  // R4: forced condition plus skipped counter leaves the counted kinds taken
  a_r4_forced_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (bo_i[BO_NO_CR] && bo_i[BO_NO_CTR] && kind_i >= BK_COND_REL && kind_i <= BK_TO_TAR) |-> taken_o);
endmodule

// File: rtl/brn_target_gen.sv
module brn_target_gen
  import brn_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned LI_W = 24,
  parameter int unsigned BD_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      kind_i,
  input  logic            aa_i,
  input  logic            mode64_i,
  input  logic            taken_i,
  input  logic [LI_W-1:0] disp_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [XLEN-1:0] lr_i,
  input  logic [XLEN-1:0] ctr_i,
  input  logic [XLEN-1:0] tar_i,
  output logic [XLEN-1:0] nia_o,
  output logic [XLEN-1:0] link_val_o
);
  localparam int unsigned HALF = XLEN / 2;
  localparam logic [XLEN-1:0] ALIGN   = ~XLEN'(3);
  localparam logic [XLEN-1:0] LOW_HALF = {{HALF{1'b0}}, {HALF{1'b1}}};

  brn_kind_e       kind;
  logic [XLEN-1:0] li_ext, bd_ext, rel, rel_tgt, tgt, seq, mask;

  assign kind = brn_kind_e'(kind_i);

  always_comb begin
    li_ext  = {{(XLEN-LI_W-2){disp_i[LI_W-1]}}, disp_i, 2'b00};
    bd_ext  = {{(XLEN-BD_W-2){disp_i[BD_W-1]}}, disp_i[BD_W-1:0], 2'b00};
    rel     = (kind == BK_UNCOND) ? li_ext : bd_ext;
    rel_tgt = aa_i ? rel : (cia_i + rel);
    case (kind)
      BK_TO_LINK:  tgt = lr_i & ALIGN;
      BK_TO_COUNT: tgt = ctr_i & ALIGN;
      BK_TO_TAR:   tgt = tar_i & ALIGN;
      default:     tgt = rel_tgt;
    endcase
    seq        = cia_i + XLEN'(4);
    mask       = mode64_i ? '1 : LOW_HALF;
    nia_o      = (taken_i ? tgt : seq) & mask;
    link_val_o = seq & mask;
  end

  // R7: register-sourced targets are word aligned
  a_r7_reg_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_i && kind_i >= BK_TO_LINK && kind_i <= BK_TO_TAR) |-> (nia_o[1:0] == 2'b00));
  // R10: narrow mode yields a zero upper half
  a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mode64_i |-> (nia_o[XLEN-1:HALF] == '0 && link_val_o[XLEN-1:HALF] == '0));
endmodule

// File: rtl/brn_resolve_unit.sv
module brn_resolve_unit
  import brn_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned CR_W = 32,
  parameter int unsigned FW   = 5,
  parameter int unsigned LI_W = 24,
  parameter int unsigned BD_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [2:0]      kind_i,
  input  logic [FW-1:0]   bo_i,
  input  logic [FW-1:0]   bi_i,
  input  logic            aa_i,
  input  logic            lk_i,
  input  logic            mode64_i,
  input  logic [LI_W-1:0] disp_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [CR_W-1:0] cr_i,
  input  logic [XLEN-1:0] tar_i,
  input  logic            ld_ctr_i,
  input  logic [XLEN-1:0] ld_ctr_val_i,
  input  logic            ld_lr_i,
  input  logic [XLEN-1:0] ld_lr_val_i,
  output logic            taken_o,
  output logic [XLEN-1:0] nia_o,
  output logic [XLEN-1:0] ctr_o,
  output logic [XLEN-1:0] lr_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [XLEN-1:0] ctr_q, ctr_d, lr_q, lr_d;
  logic [XLEN-1:0] ctr_next, link_val;
  logic            reg_en;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  brn_cond_eval #(.XLEN(XLEN), .CR_W(CR_W), .FW(FW)) u_cond (
    .clk(clk), .rst_n(rst_int_n), .kind_i(kind_i), .bo_i(bo_i), .bi_i(bi_i),
    .mode64_i(mode64_i), .cr_i(cr_i), .ctr_i(ctr_q),
    .ctr_next_o(ctr_next), .taken_o(taken_o));

  brn_target_gen #(.XLEN(XLEN), .LI_W(LI_W), .BD_W(BD_W)) u_tgt (
    .clk(clk), .rst_n(rst_int_n), .kind_i(kind_i), .aa_i(aa_i), .mode64_i(mode64_i),
    .taken_i(taken_o), .disp_i(disp_i), .cia_i(cia_i), .lr_i(lr_q), .ctr_i(ctr_q),
    .tar_i(tar_i), .nia_o(nia_o), .link_val_o(link_val));

  always_comb begin
    ctr_d  = ctr_q;
    lr_d   = lr_q;
    reg_en = valid_i || ld_ctr_i || ld_lr_i;
    if (valid_i) begin
      ctr_d = ctr_next;
      if (lk_i) lr_d = link_val;
    end else begin
      if (ld_ctr_i) ctr_d = ld_ctr_val_i;
      if (ld_lr_i)  lr_d  = ld_lr_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      lr_q  <= '0;
    end else if (reg_en) begin
      ctr_q <= ctr_d;
      lr_q  <= lr_d;
    end
  end

  assign ctr_o = ctr_q;
  assign lr_o  = lr_q;

  // R2: decrementing kinds with counting enabled step the counter down by one
  a_r2_ctr_decrements: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_i && !bo_i[BO_NO_CTR] &&
     (kind_i == BK_COND_REL || kind_i == BK_TO_LINK || kind_i == BK_TO_TAR))
    |=> (ctr_o == $past(ctr_o) - XLEN'(1)));
  // R2: all other valid cycles leave the counter alone
  a_r2_ctr_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_i && (bo_i[BO_NO_CTR] || kind_i == BK_UNCOND || kind_i > BK_TO_LINK && kind_i != BK_TO_TAR))
    |=> $stable(ctr_o));
  // R9: without the save flag the return register is untouched
  a_r9_lr_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_i && !lk_i) |=> $stable(lr_o));
endmodule

// File: tb/brn_resolve_unit_tb_top.sv
module brn_resolve_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, aa_i, lk_i, mode64_i, ld_ctr_i, ld_lr_i;
  logic [2:0]  kind_i;
  logic [4:0]  bo_i, bi_i;
  logic [23:0] disp_i;
  logic [63:0] cia_i, tar_i, ld_ctr_val_i, ld_lr_val_i;
  logic [31:0] cr_i;
  logic        taken_o;
  logic [63:0] nia_o, ctr_o, lr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brn_resolve_unit dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i), .bo_i(bo_i),
    .bi_i(bi_i), .aa_i(aa_i), .lk_i(lk_i), .mode64_i(mode64_i), .disp_i(disp_i),
    .cia_i(cia_i), .cr_i(cr_i), .tar_i(tar_i), .ld_ctr_i(ld_ctr_i),
    .ld_ctr_val_i(ld_ctr_val_i), .ld_lr_i(ld_lr_i), .ld_lr_val_i(ld_lr_val_i),
    .taken_o(taken_o), .nia_o(nia_o), .ctr_o(ctr_o), .lr_o(lr_o));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      if (failures < 20)
        $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] ctr_seed [4];
    logic [4:0]  bi_set [3];
    logic [23:0] disp_set [3];
    logic [63:0] lr_seed;
    ctr_seed = '{64'd1, 64'd2, 64'd0, 64'h0000_0001_0000_0001};
    bi_set   = '{5'd0, 5'd13, 5'd31};
    disp_set = '{24'h802001, 24'h000010, 24'h7FFFFC};
    lr_seed  = 64'hFFFF_0000_0000_4007;

    rst_n = 1'b0; valid_i = 0; kind_i = 0; bo_i = 0; bi_i = 0; aa_i = 0; lk_i = 0;
    mode64_i = 1; disp_i = 0; cia_i = 64'hABCD_0000_8000_1000; cr_i = 32'hA5C3_0F96;
    tar_i = 64'h0000_0000_00C0_FFEE; ld_ctr_i = 0; ld_lr_i = 0;
    ld_ctr_val_i = 0; ld_lr_val_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: loads take effect while no branch is valid
    ld_ctr_i = 1; ld_lr_i = 1; ld_ctr_val_i = 64'h55; ld_lr_val_i = 64'h77;
    @(negedge clk);
    ld_ctr_i = 0; ld_lr_i = 0;
    check(ctr_o == 64'h55, "R11 ctr load", ctr_o, 64'h55);
    check(lr_o == 64'h77, "R11 lr load", lr_o, 64'h77);
    // R11: loads ignored under a valid branch (kind 0, LK=0: nothing changes)
    valid_i = 1; kind_i = 0; ld_ctr_i = 1; ld_lr_i = 1;
    ld_ctr_val_i = 64'h99; ld_lr_val_i = 64'h88;
    @(negedge clk);
    valid_i = 0; ld_ctr_i = 0; ld_lr_i = 0;
    check(ctr_o == 64'h55, "R11 ctr load ignored", ctr_o, 64'h55);
    check(lr_o == 64'h77, "R11 lr load ignored", lr_o, 64'h77);

    // R1: reset clears the held registers
    rst_n = 1'b0;
    #1;
    check(ctr_o == 64'd0, "R1 ctr reset", ctr_o, 64'd0);
    check(lr_o == 64'd0, "R1 lr reset", lr_o, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 6; k++)
      for (int bo = 0; bo < 32; bo++)
        for (int bx = 0; bx < 3; bx++)
          for (int cx = 0; cx < 4; cx++)
            for (int m = 0; m < 2; m++)
              for (int lk = 0; lk < 2; lk++)
                for (int aa = 0; aa < 2; aa++) begin
                  logic [63:0] c0, mask, ctrn, rel, tgt, seq, e_nia, e_lr;
                  logic [4:0]  o;
                  bit nz, cok, rok, uses, tk;
                  int bi;
                  c0 = ctr_seed[cx];
                  o  = 5'(bo);
                  bi = int'(bi_set[bx]);
                  // model
                  mask = (m == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
                  uses = (k == 1) || (k == 2) || (k == 4);
                  ctrn = (uses && !o[2]) ? c0 - 64'd1 : c0;
                  nz   = (m == 1) ? (ctrn != 0) : (ctrn[31:0] != 0);
                  cok  = o[2] || (nz != o[1]);
                  rok  = o[4] || (((cr_i >> (31 - bi)) & 32'd1) == {31'd0, o[3]});
                  tk   = (k == 0) ? 1'b1 : (k == 3) ? rok : uses ? (cok && rok) : 1'b0;
                  if (k == 0) rel = 64'($signed({disp_set[bx], 2'b00}));
                  else        rel = 64'($signed({disp_set[bx][13:0], 2'b00}));
                  seq = cia_i + 64'd4;
                  case (k)
                    2: tgt = {lr_seed[63:2], 2'b00};
                    3: tgt = {c0[63:2], 2'b00};
                    4: tgt = {tar_i[63:2], 2'b00};
                    default: tgt = (aa == 1) ? rel : cia_i + rel;
                  endcase
                  e_nia = (tk ? tgt : seq) & mask;
                  e_lr  = (lk == 1) ? (seq & mask) : lr_seed;
                  // stimulus
                  ld_ctr_i = 1; ld_lr_i = 1; ld_ctr_val_i = c0; ld_lr_val_i = lr_seed;
                  @(negedge clk);
                  ld_ctr_i = 0; ld_lr_i = 0;
                  valid_i = 1; kind_i = 3'(k); bo_i = o; bi_i = 5'(bi); aa_i = 1'(aa);
                  lk_i = 1'(lk); mode64_i = 1'(m); disp_i = disp_set[bx];
                  #1;
                  check(taken_o == tk, "R3 R4 R5 taken", {63'd0, taken_o}, {63'd0, tk});
                  if (tk && k < 2)
                    check(nia_o == e_nia, "R6 R10 relative target", nia_o, e_nia);
                  else if (tk)
                    check(nia_o == e_nia, "R7 R10 register target", nia_o, e_nia);
                  else
                    check(nia_o == e_nia, "R8 R10 fall through", nia_o, e_nia);
                  @(negedge clk);
                  valid_i = 0;
                  check(ctr_o == ctrn, "R2 counter update", ctr_o, ctrn);
                  check(lr_o == e_lr, "R9 R10 return register", lr_o, e_lr);
                end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule